// File: doc/BRIEF.md
# Dual-Mapped Internal Data Memory

This block holds the 256-byte internal scratch RAM of an 8-bit microcontroller core. It also decides which accesses reach that RAM. Every cycle the core may issue one read and one write. Each access carries a 2-bit mode.

- **Direct mode** reaches RAM below 0x80. At 0x80 and above it is handed to the special function register (SFR) port.
- **Indirect mode** reaches every byte of RAM, so the upper 128 bytes are visible only this way.
- **Register mode** names one of eight registers in the bank chosen by the bank-select input.
- **Bit mode** names one of 128 bits packed into bytes 0x20 to 0x2F.

Reads are registered. A read result appears on `rd_data` one cycle after the request and stays there until the next read. A bit write is performed in place on the storage flops. It alters one bit and completes in the same cycle as any byte write. The SFR port is combinational: strobe, address and write data follow the request in its own cycle. SFR read data is sampled at the clock edge that ends the request cycle.

Top module: `dual_map_iram`

## Requirements
- R1: After reset every RAM byte reads as 0x00, `rd_data` is 0x00 and neither SFR strobe is high.
- R2: A read request (`rd_en`=1) puts its result on `rd_data` after the next rising clock edge. While `rd_en` is 0, `rd_data` holds its value.
- R3: In indirect mode (code 2'b01), addresses 0x80 to 0xFF read and write RAM bytes 0x80 to 0xFF and raise no SFR strobe.
- R4: A direct-mode (code 2'b00) write at 0x80 to 0xFF raises `sfr_wr_stb` in the same cycle with `sfr_wr_addr`=address and `sfr_wdata`=`wr_data`. It leaves RAM unchanged.
- R5: A direct-mode read at 0x80 to 0xFF raises `sfr_rd_stb` in the same cycle with `sfr_rd_addr`=address. It returns on `rd_data` the `sfr_rdata` value present at the end of that cycle, and does not read RAM.
- R6: Addresses 0x00 to 0x7F give the same RAM byte in direct and indirect mode, for both reads and writes.
- R7: Register mode (code 2'b10) addresses byte `bank_sel`*8 + addr[2:0]. Address bits 7:3 are ignored.
- R8: Bit mode (code 2'b11) addresses bit addr[2:0] of byte 0x20 + addr[6:3], and addr[7] is ignored. A bit read returns {7'b0, bit}.
- R9: A bit-mode write stores `wr_data[0]` into the selected bit and leaves the other seven bits of that byte unchanged.
- R10: A read and a write that hit the same byte in the same cycle return the byte's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Active register bank |
| rd_en | input | 1 | Read request |
| rd_mode | input | 2 | Read mode: 00 direct, 01 indirect, 10 register, 11 bit |
| rd_addr | input | 8 | Read address, meaning set by `rd_mode` |
| wr_en | input | 1 | Write request |
| wr_mode | input | 2 | Write mode, same encoding as `rd_mode` |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data; bit 0 is the value in bit mode |
| rd_data | output | 8 | Registered read result |
| sfr_rd_stb | output | 1 | SFR read strobe |
| sfr_rd_addr | output | 8 | SFR read address |
| sfr_rdata | input | 8 | SFR read data |
| sfr_wr_stb | output | 1 | SFR write strobe |
| sfr_wr_addr | output | 8 | SFR write address |
| sfr_wdata | output | 8 | SFR write data |

## Verification
Address mapping faults show up at the ports only when the wrongly mapped byte is read back. The bench therefore keeps a full byte image of the RAM and mixes all four modes randomly over the same locations, so that a faulty bank, bit-field or dual-map decode corrupts a value read within a few hundred cycles. A wrong SFR routing decision is visible within the same cycle on the strobes. It is also visible one cycle later on `rd_data`, which then carries RAM contents instead of `sfr_rdata`, or the reverse. A bit write that disturbs neighbouring bits stays hidden until that byte is read in a byte mode, which the random mix and the directed cases both do.

// File: rtl/dual_map_iram.sv
module dual_map_iram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_sel,
  input  logic          rd_en,
  input  logic [1:0]    rd_mode,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [1:0]    wr_mode,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sfr_rd_stb,
  output logic [AW-1:0] sfr_rd_addr,
  input  logic [DW-1:0] sfr_rdata,
  output logic          sfr_wr_stb,
  output logic [AW-1:0] sfr_wr_addr,
  output logic [DW-1:0] sfr_wdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] M_DIR = 2'b00, M_IND = 2'b01, M_REG = 2'b10, M_BIT = 2'b11;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ra, wa;
  logic          wr_ram;
  logic [DW-1:0] bw_mask;

  function automatic logic [AW-1:0] map_addr(input logic [1:0] mode,
                                             input logic [AW-1:0] a,
                                             input logic [1:0] bank);
    case (mode)
      M_REG:   map_addr = AW'({bank, a[2:0]});
      M_BIT:   map_addr = AW'({4'h2, a[6:3]});
      default: map_addr = a;
    endcase
  endfunction

  assign ra          = map_addr(rd_mode, rd_addr, bank_sel);
  assign wa          = map_addr(wr_mode, wr_addr, bank_sel);
  assign sfr_rd_stb  = rd_en && rd_mode == M_DIR && rd_addr[AW-1];
  assign sfr_wr_stb  = wr_en && wr_mode == M_DIR && wr_addr[AW-1];
  assign sfr_rd_addr = rd_addr;
  assign sfr_wr_addr = wr_addr;
  assign sfr_wdata   = wr_data;
  assign wr_ram      = wr_en && !sfr_wr_stb;
  assign bw_mask     = DW'(1) << wr_addr[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (rd_en) begin
        if (sfr_rd_stb)
          rd_data <= sfr_rdata;
        else if (rd_mode == M_BIT)
          rd_data <= DW'(mem[ra][rd_addr[2:0]]);
        else
          rd_data <= mem[ra];
      end
      if (wr_ram) begin
        if (wr_mode == M_BIT)
          mem[wa][wr_addr[2:0]] <= wr_data[0];
        else
          mem[wa] <= wr_data;
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_sfr_ram_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr_stb |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));

  p_sfr_read_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_rd_stb |=> rd_data == $past(sfr_rdata));

  p_bit_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ram && wr_mode == M_BIT |=> mem[$past(wa)][$past(wr_addr[2:0])] == $past(wr_data[0]));

  p_bit_neighbours_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ram && wr_mode == M_BIT |=> (mem[$past(wa)] & ~$past(bw_mask)) == ($past(mem[wa]) & ~$past(bw_mask)));

  p_old_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !sfr_rd_stb && rd_mode != M_BIT && wr_ram && ra == wa |=> rd_data == $past(mem[ra]));

  p_no_sfr_indirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_mode != M_DIR |-> !sfr_rd_stb);
endmodule

// File: tb/dual_map_iram_tb.sv
module dual_map_iram_tb;
  logic       clk = 0, rst_n = 0;
  logic [1:0] bank_sel = 0, rd_mode = 0, wr_mode = 0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] rd_addr = 0, wr_addr = 0, wr_data = 0, sfr_rdata = 0;
  logic [7:0] rd_data, sfr_rd_addr, sfr_wr_addr, sfr_wdata;
  logic       sfr_rd_stb, sfr_wr_stb;

  int total = 0, fails = 0;
  logic [7:0] model [256];
  logic [7:0] exp_rd = 0;
  string      exp_tag = "R1";

  always #5 clk = ~clk;

  dual_map_iram u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .rd_en(rd_en), .rd_mode(rd_mode), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .sfr_rd_stb(sfr_rd_stb), .sfr_rd_addr(sfr_rd_addr),
    .sfr_rdata(sfr_rdata), .sfr_wr_stb(sfr_wr_stb), .sfr_wr_addr(sfr_wr_addr),
    .sfr_wdata(sfr_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int byte_of(input logic [1:0] m, input logic [7:0] a, input logic [1:0] b);
    if (m == 2'b10) return b * 8 + (a % 8);
    if (m == 2'b11) return 32 + ((a % 128) / 8);
    return a;
  endfunction

  function automatic string tag_of(input logic [1:0] m, input logic [7:0] a);
    if (m == 2'b10) return "R7";
    if (m == 2'b11) return "R8";
    if (m == 2'b01) return (a >= 8'h80) ? "R3" : "R6";
    return (a >= 8'h80) ? "R5" : "R6";
  endfunction

  task automatic cyc(input logic re, input logic [1:0] rm, input logic [7:0] ra,
                     input logic we, input logic [1:0] wm, input logic [7:0] wa,
                     input logic [7:0] wd, input logic [1:0] bk, input logic [7:0] sd);
    logic rsfr, wsfr;
    int rb, wb;
    rd_en = re; rd_mode = rm; rd_addr = ra;
    wr_en = we; wr_mode = wm; wr_addr = wa; wr_data = wd;
    bank_sel = bk; sfr_rdata = sd;
    #1;
    rsfr = re && rm == 2'b00 && ra >= 8'h80;
    wsfr = we && wm == 2'b00 && wa >= 8'h80;
    chk(rsfr ? "R5" : "R3", {31'b0, sfr_rd_stb}, {31'b0, rsfr});
    chk(wsfr ? "R4" : "R3", {31'b0, sfr_wr_stb}, {31'b0, wsfr});
    if (rsfr) chk("R5", {24'b0, sfr_rd_addr}, {24'b0, ra});
    if (wsfr) begin
      chk("R4", {24'b0, sfr_wr_addr}, {24'b0, wa});
      chk("R4", {24'b0, sfr_wdata}, {24'b0, wd});
    end
    rb = byte_of(rm, ra, bk);
    wb = byte_of(wm, wa, bk);
    if (re) begin
      if (rsfr) exp_rd = sd;
      else if (rm == 2'b11) exp_rd = {7'b0, model[rb][ra % 8]};
      else exp_rd = model[rb];
      exp_tag = tag_of(rm, ra);
      if (we && !wsfr && rb == wb && !rsfr) exp_tag = "R10";
    end else exp_tag = "R2";
    if (we && !wsfr) begin
      if (wm == 2'b11) model[wb][wa % 8] = wd[0];
      else model[wb] = wd;
    end
    @(negedge clk);
    chk(exp_tag, {24'b0, rd_data}, {24'b0, exp_rd});
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", {24'b0, rd_data}, 32'h0);
    chk("R1", {30'b0, sfr_rd_stb, sfr_wr_stb}, 32'h0);
    rst_n = 1;
    cyc(1, 2'b01, 8'hFF, 0, 0, 0, 0, 0, 8'h5A);
    chk("R1", {24'b0, rd_data}, 32'h0);
    // R3 upper RAM via indirect, then direct same address goes to SFR (R5)
    cyc(0, 0, 0, 1, 2'b01, 8'h90, 8'hC3, 0, 0);
    cyc(1, 2'b01, 8'h90, 1, 2'b00, 8'h90, 8'h11, 0, 8'h77);
    cyc(1, 2'b00, 8'h90, 0, 0, 0, 0, 0, 8'h3C);
    cyc(1, 2'b01, 8'h90, 0, 0, 0, 0, 0, 8'h00);
    chk("R4", {24'b0, rd_data}, 32'hC3);
    // R2 hold
    cyc(0, 2'b01, 8'h00, 0, 0, 0, 0, 0, 0);
    cyc(0, 2'b00, 8'hA0, 0, 0, 0, 0, 0, 8'hEE);
    // R7 bank mapping, high address bits ignored
    cyc(0, 0, 0, 1, 2'b10, 8'hFD, 8'h5E, 2'd3, 0);
    cyc(1, 2'b00, 8'h1D, 0, 0, 0, 0, 0, 0);
    chk("R7", {24'b0, rd_data}, 32'h5E);
    // R9 bit write keeps neighbours; R8 addr[7] ignored
    cyc(0, 0, 0, 1, 2'b00, 8'h2A, 8'hA5, 0, 0);
    cyc(0, 0, 0, 1, 2'b11, 8'hD1, 8'h01, 0, 0);
    cyc(1, 2'b01, 8'h2A, 1, 2'b11, 8'h57, 8'h00, 0, 0);
    cyc(1, 2'b00, 8'h2A, 0, 0, 0, 0, 0, 0);
    chk("R9", {24'b0, rd_data}, 32'h27);
    // R10 same-cycle read/write
    cyc(1, 2'b00, 8'h40, 1, 2'b01, 8'h40, 8'h99, 0, 0);
    chk("R10", {24'b0, rd_data}, 32'h00);
    cyc(1, 2'b00, 8'h40, 0, 0, 0, 0, 0, 0);
    chk("R6", {24'b0, rd_data}, 32'h99);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a1, a2;
      a1 = 8'($urandom);
      a2 = ($urandom % 4 == 0) ? a1 : 8'($urandom);
      cyc(1'($urandom % 4 != 0), 2'($urandom), a1,
          1'($urandom % 3 != 0), 2'($urandom), a2,
          8'($urandom), 2'($urandom), 8'($urandom));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule